// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Dispatcher

This block holds a 64-bit interrupt command, written as a low word and a high word. A processor uses it to send an interrupt to any of `NUM_CPUS` processors. A write to the high word stores the destination. An accepted write to the low word builds a message from both words and expands it into a bitmask of remote processors. That bitmask is presented for one cycle on the outbound port. If the local processor is among the targets, the same message is presented on a separate loopback port in the same cycle. The dispatcher does not model the interconnect that carries the outbound message.

A delivery-status flag shows whether a send is still outstanding. While the flag is set, further low-word writes are dropped. The flag clears once one acknowledgement has returned for every remote target. If there were no remote targets, it clears one cycle after the send. Lowest-priority arbitration between processors is not provided. A lowest-priority request that names its destination through the destination field sends nothing and raises an error pulse instead.

Top module: `ipi_dispatch`

## Requirements
- R1: A low-word write while `busy` is high is dropped. `lo_rdata` keeps its value, and no outbound, loopback or error pulse follows.
- R2: A low-word write while `busy` is low is accepted. On the next edge `busy` rises and `lo_rdata` shows the written value with bit 12 set. `out_valid` and `loop_valid` are single-cycle pulses that occur only in the cycle `busy` rises.
- R3: With k remote targets (k ≥ 1), `busy` stays high through k−1 acknowledgement cycles and falls at the edge that takes the k-th. An `ack_in` while idle has no effect.
- R4: When an accepted send has no remote target, `busy` falls one cycle after it rose.
- R5: Shorthand 0 (bits 19:18 of the low word) with the logical destination mode (bit 11 = 1) uses the destination byte as a mask in which bit i selects processor i. It sends no loopback.
- R6: Shorthand 0 in physical mode (bit 11 = 0) with destination 0xFF targets every processor other than `self_id` remotely, and loops the message back to self.
- R7: Shorthand 0 in physical mode with any other destination targets that single processor. The message is looped back instead when the destination equals `self_id`. A destination at or above `NUM_CPUS` reaches nobody.
- R8: Shorthand 1 loops back only. Shorthand 2 loops back and targets all others. Shorthand 3 targets all others without loopback.
- R9: The low word supplies the vector (bits 7:0), delivery mode (10:8), destination mode (11), level (14) and trigger (15). The high word supplies the destination (bits 31:24). A high-word write in the same cycle as a low-word write is used by that send. `hi_rdata` returns the last high-word write.
- R10: Delivery mode 1 (lowest priority) with shorthand 0 sends nothing and pulses `lowpri_err` for one cycle. With any other shorthand it is dispatched normally.
- R11: After reset, `busy`, `out_valid`, `loop_valid` and `lowpri_err` are low, and both read-back words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| self_id | input | 8 | Index of the local processor |
| wr_lo | input | 1 | Low-word write strobe |
| lo_wdata | input | 32 | Low-word write data |
| wr_hi | input | 1 | High-word write strobe |
| hi_wdata | input | 32 | High-word write data |
| ack_in | input | 1 | One delivery acknowledgement this cycle |
| lo_rdata | output | 32 | Low-word read-back, bit 12 = delivery status |
| hi_rdata | output | 32 | High-word read-back |
| busy | output | 1 | Delivery status |
| out_valid | output | 1 | Outbound message present |
| out_mask | output | NUM_CPUS | Remote destination processors |
| out_vector | output | 8 | Message vector |
| out_mode | output | 3 | Message delivery mode |
| out_logical | output | 1 | Message destination mode |
| out_level | output | 1 | Message level |
| out_trigger | output | 1 | Message trigger |
| out_dest | output | 8 | Message destination byte |
| loop_valid | output | 1 | Message for the local processor |
| loop_vector | output | 8 | Looped-back vector |
| loop_mode | output | 3 | Looped-back delivery mode |
| loop_level | output | 1 | Looped-back level |
| loop_trigger | output | 1 | Looped-back trigger |
| lowpri_err | output | 1 | Unsupported lowest-priority request |

## Verification
The bench builds the dispatcher with `NUM_CPUS = 4`. It sweeps every shorthand, both destination modes, every destination from 0 to 15 plus 0xFF, and `self_id` from 0 to 4. Because 4 is an out-of-range index, the sweep covers loopback, self-exclusion, out-of-range destinations and logical mask truncation. For each case the bench returns exactly the expected number of acknowledgements, so the busy window is checked at every length from zero to four. Dropped writes are issued during that window.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

    typedef enum logic [1:0] {
        SH_FIELD    = 2'd0,
        SH_SELF     = 2'd1,
        SH_ALL_INCL = 2'd2,
        SH_ALL_EXCL = 2'd3
    } shorthand_e;

    localparam logic [2:0] MODE_LOWEST = 3'd1;
    localparam logic [7:0] DEST_ALL    = 8'hFF;
    localparam int         STATUS_BIT  = 12;

    typedef struct packed {
        logic [7:0] dest;
        shorthand_e sh;
        logic       trigger;
        logic       level;
        logic       logical;
        logic [2:0] mode;
        logic [7:0] vector;
    } ipi_msg_t;

    function automatic ipi_msg_t unpack_cmd(input logic [31:0] lo, input logic [31:0] hi);
        ipi_msg_t m;
        m.vector  = lo[7:0];
        m.mode    = lo[10:8];
        m.logical = lo[11];
        m.level   = lo[14];
        m.trigger = lo[15];
        m.sh      = shorthand_e'(lo[19:18]);
        m.dest    = hi[31:24];
        return m;
    endfunction

endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_lo,
    input  logic [31:0] lo_wdata,
    input  logic        wr_hi,
    input  logic [31:0] hi_wdata,
    input  logic        busy,
    output logic        accept,
    output logic [31:0] hi_eff,
    output logic [31:0] lo_rdata,
    output logic [31:0] hi_rdata
);
    import ipi_pkg::*;

    logic [31:0] lo_q;
    logic [31:0] hi_q;

    assign accept = wr_lo && !busy;
    assign hi_eff = wr_hi ? hi_wdata : hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (wr_hi)
                hi_q <= hi_wdata;
            if (accept) begin
                lo_q             <= lo_wdata;
                lo_q[STATUS_BIT] <= 1'b0;
            end
        end
    end

    always_comb begin
        lo_rdata             = lo_q;
        lo_rdata[STATUS_BIT] = busy;
    end
    assign hi_rdata = hi_q;

endmodule

// File: rtl/ipi_dest_expand.sv
module ipi_dest_expand #(
    parameter int NUM_CPUS = 8
) (
    input  ipi_pkg::shorthand_e  sh,
    input  logic                 logical,
    input  logic [2:0]           mode,
    input  logic [7:0]           dest,
    input  logic [7:0]           self_id,
    output logic [NUM_CPUS-1:0]  remote_mask,
    output logic                 loop_hit,
    output logic                 unsupported
);
    import ipi_pkg::*;

    logic [NUM_CPUS-1:0]   self_oh;
    logic [NUM_CPUS-1:0]   dest_oh;
    logic [NUM_CPUS-1:0]   others;
    logic [NUM_CPUS+7:0]   dest_ext;

    always_comb begin
        for (int i = 0; i < NUM_CPUS; i++) begin
            self_oh[i] = (self_id == 8'(i));
            dest_oh[i] = (dest == 8'(i));
        end
    end

    assign others   = ~self_oh;
    assign dest_ext = {{NUM_CPUS{1'b0}}, dest};

    always_comb begin
        remote_mask = '0;
        loop_hit    = 1'b0;
        unsupported = 1'b0;
        unique case (sh)
            SH_FIELD: begin
                if (mode == MODE_LOWEST) begin
                    unsupported = 1'b1;
                end else if (logical) begin
                    remote_mask = dest_ext[NUM_CPUS-1:0];
                end else if (dest == DEST_ALL) begin
                    remote_mask = others;
                    loop_hit    = 1'b1;
                end else if (dest == self_id) begin
                    loop_hit    = 1'b1;
                end else begin
                    remote_mask = dest_oh;
                end
            end
            SH_SELF: begin
                loop_hit = 1'b1;
            end
            SH_ALL_INCL: begin
                remote_mask = others;
                loop_hit    = 1'b1;
            end
            SH_ALL_EXCL: begin
                remote_mask = others;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ipi_busy_track.sv
module ipi_busy_track #(
    parameter int NUM_CPUS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic [NUM_CPUS-1:0] remote_mask,
    input  logic                ack_in,
    output logic                busy
);
    localparam int CNT_W = $clog2(NUM_CPUS + 1);

    logic [CNT_W-1:0] pending_q;
    logic [CNT_W-1:0] load_cnt;

    always_comb begin
        load_cnt = '0;
        for (int i = 0; i < NUM_CPUS; i++)
            load_cnt = load_cnt + CNT_W'(remote_mask[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q <= '0;
            busy      <= 1'b0;
        end else if (accept) begin
            pending_q <= load_cnt;
            busy      <= 1'b1;
        end else if (busy) begin
            if (pending_q == '0) begin
                busy <= 1'b0;
            end else if (ack_in) begin
                pending_q <= pending_q - 1'b1;
                if (pending_q == CNT_W'(1))
                    busy <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch #(
    parameter int NUM_CPUS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [7:0]          self_id,
    input  logic                wr_lo,
    input  logic [31:0]         lo_wdata,
    input  logic                wr_hi,
    input  logic [31:0]         hi_wdata,
    input  logic                ack_in,
    output logic [31:0]         lo_rdata,
    output logic [31:0]         hi_rdata,
    output logic                busy,
    output logic                out_valid,
    output logic [NUM_CPUS-1:0] out_mask,
    output logic [7:0]          out_vector,
    output logic [2:0]          out_mode,
    output logic                out_logical,
    output logic                out_level,
    output logic                out_trigger,
    output logic [7:0]          out_dest,
    output logic                loop_valid,
    output logic [7:0]          loop_vector,
    output logic [2:0]          loop_mode,
    output logic                loop_level,
    output logic                loop_trigger,
    output logic                lowpri_err
);
    import ipi_pkg::*;

    logic                accept;
    logic [31:0]         hi_eff;
    ipi_msg_t            msg_d;
    ipi_msg_t            msg_q;
    logic [NUM_CPUS-1:0] remote_mask;
    logic                loop_hit;
    logic                unsupported;

    ipi_cmd_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_lo    (wr_lo),
        .lo_wdata (lo_wdata),
        .wr_hi    (wr_hi),
        .hi_wdata (hi_wdata),
        .busy     (busy),
        .accept   (accept),
        .hi_eff   (hi_eff),
        .lo_rdata (lo_rdata),
        .hi_rdata (hi_rdata)
    );

    assign msg_d = unpack_cmd(lo_wdata, hi_eff);

    ipi_dest_expand #(.NUM_CPUS(NUM_CPUS)) u_expand (
        .sh          (msg_d.sh),
        .logical     (msg_d.logical),
        .mode        (msg_d.mode),
        .dest        (msg_d.dest),
        .self_id     (self_id),
        .remote_mask (remote_mask),
        .loop_hit    (loop_hit),
        .unsupported (unsupported)
    );

    ipi_busy_track #(.NUM_CPUS(NUM_CPUS)) u_busy (
        .clk         (clk),
        .rst         (rst),
        .accept      (accept),
        .remote_mask (remote_mask),
        .ack_in      (ack_in),
        .busy        (busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            loop_valid <= 1'b0;
            lowpri_err <= 1'b0;
            out_mask   <= '0;
            msg_q      <= '0;
        end else begin
            out_valid  <= accept && (remote_mask != '0);
            loop_valid <= accept && loop_hit;
            lowpri_err <= accept && unsupported;
            if (accept) begin
                out_mask <= remote_mask;
                msg_q    <= msg_d;
            end
        end
    end

    assign out_vector   = msg_q.vector;
    assign out_mode     = msg_q.mode;
    assign out_logical  = msg_q.logical;
    assign out_level    = msg_q.level;
    assign out_trigger  = msg_q.trigger;
    assign out_dest     = msg_q.dest;
    assign loop_vector  = msg_q.vector;
    assign loop_mode    = msg_q.mode;
    assign loop_level   = msg_q.level;
    assign loop_trigger = msg_q.trigger;

endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk #(
    parameter int NUM_CPUS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_lo,
    input logic                ack_in,
    input logic                busy,
    input logic                out_valid,
    input logic [NUM_CPUS-1:0] out_mask,
    input logic                loop_valid,
    input logic                lowpri_err
);

    p_drop_when_busy_r1: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_lo) |=> (!out_valid && !loop_valid && !lowpri_err));

    p_accept_sets_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_lo) |=> busy);

    p_no_emit_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!out_valid && !loop_valid));

    p_wait_for_ack_r3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !ack_in) |=> busy);

    p_local_only_clears_r4: assert property (@(posedge clk) disable iff (rst)
        ((loop_valid && !out_valid) || lowpri_err) |=> !busy);

    p_outbound_has_target_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_mask != '0));

    p_error_is_silent_r10: assert property (@(posedge clk) disable iff (rst)
        lowpri_err |-> (!out_valid && !loop_valid));

endmodule

bind ipi_dispatch ipi_dispatch_chk #(.NUM_CPUS(NUM_CPUS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_lo      (wr_lo),
    .ack_in     (ack_in),
    .busy       (busy),
    .out_valid  (out_valid),
    .out_mask   (out_mask),
    .loop_valid (loop_valid),
    .lowpri_err (lowpri_err)
);

// File: tb/tb_ipi_dispatch.sv
module tb_ipi_dispatch;
    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   self_id = '0;
    logic         wr_lo = 1'b0;
    logic [31:0]  lo_wdata = '0;
    logic         wr_hi = 1'b0;
    logic [31:0]  hi_wdata = '0;
    logic         ack_in = 1'b0;
    logic [31:0]  lo_rdata, hi_rdata;
    logic         busy, out_valid, loop_valid, lowpri_err;
    logic [N-1:0] out_mask;
    logic [7:0]   out_vector, out_dest, loop_vector;
    logic [2:0]   out_mode, loop_mode;
    logic         out_logical, out_level, out_trigger, loop_level, loop_trigger;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ipi_dispatch #(.NUM_CPUS(N)) dut (
        .clk(clk), .rst(rst), .self_id(self_id),
        .wr_lo(wr_lo), .lo_wdata(lo_wdata), .wr_hi(wr_hi), .hi_wdata(hi_wdata),
        .ack_in(ack_in), .lo_rdata(lo_rdata), .hi_rdata(hi_rdata), .busy(busy),
        .out_valid(out_valid), .out_mask(out_mask), .out_vector(out_vector),
        .out_mode(out_mode), .out_logical(out_logical), .out_level(out_level),
        .out_trigger(out_trigger), .out_dest(out_dest),
        .loop_valid(loop_valid), .loop_vector(loop_vector), .loop_mode(loop_mode),
        .loop_level(loop_level), .loop_trigger(loop_trigger), .lowpri_err(lowpri_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_lo(int sh, int dm, int mode, int lvl, int trg, int vec);
        return {12'b0, 2'(sh), 2'b0, 1'(trg), 1'(lvl), 1'b0, 1'b0, 1'(dm), 3'(mode), 8'(vec)};
    endfunction

    function automatic logic [N-1:0] exp_mask(int self, int sh, int dm, int dest, int mode);
        logic [N-1:0] oth = '1;
        if (self < N) oth[self] = 1'b0;
        case (sh)
            0: begin
                if (mode == 1) return '0;
                if (dm == 1) return N'(dest);
                if (dest == 255) return oth;
                if (dest == self || dest >= N) return '0;
                return N'(1 << dest);
            end
            1: return '0;
            default: return oth;
        endcase
    endfunction

    function automatic logic exp_loop(int self, int sh, int dm, int dest, int mode);
        case (sh)
            0: return (mode != 1) && (dm == 0) && (dest == 255 || dest == self);
            3: return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    task automatic do_ack();
        @(negedge clk) ack_in = 1'b1;
        @(negedge clk) ack_in = 1'b0;
    endtask

    task automatic send(input logic [31:0] lo, input logic [31:0] hi);
        @(negedge clk);
        wr_hi = 1'b1; hi_wdata = hi;
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b1; lo_wdata = lo;
        @(negedge clk);
        wr_lo = 1'b0;
    endtask

    task automatic run_case(int self, int sh, int dm, int dest, int mode, int vec, int lvl, int trg);
        logic [31:0]  lo = mk_lo(sh, dm, mode, lvl, trg, vec);
        logic [N-1:0] em = exp_mask(self, sh, dm, dest, mode);
        logic         el = exp_loop(self, sh, dm, dest, mode);
        logic         ee = (sh == 0) && (mode == 1);
        int           k  = $countones(em);
        self_id = 8'(self);
        send(lo, {8'(dest), 24'h0});
        chk("R2 busy set", busy, 1);
        chk("R2 lo readback", lo_rdata, lo | 32'h1000);
        chk("R9 hi readback", hi_rdata, {8'(dest), 24'h0});
        chk("R5-R8 out_valid", out_valid, (em != 0));
        if (em != 0) begin
            chk("R5 R6 R7 R8 out_mask", out_mask, em);
            chk("R9 fields", {out_vector, out_mode, out_logical, out_level, out_trigger, out_dest},
                {8'(vec), 3'(mode), 1'(dm), 1'(lvl), 1'(trg), 8'(dest)});
        end
        chk("R6 R7 R8 loop_valid", loop_valid, el);
        if (el)
            chk("R9 loop fields", {loop_vector, loop_mode, loop_level, loop_trigger},
                {8'(vec), 3'(mode), 1'(lvl), 1'(trg)});
        chk("R10 lowpri_err", lowpri_err, ee);
        if (k == 0) begin
            @(negedge clk);
            chk("R4 busy clears", busy, 0);
        end else begin
            for (int a = 0; a < k - 1; a++) begin
                do_ack();
                chk("R3 busy held", busy, 1);
                if (a == 0) begin
                    @(negedge clk) wr_lo = 1'b1; lo_wdata = lo ^ 32'h55;
                    @(negedge clk) wr_lo = 1'b0;
                    chk("R1 no send", {out_valid, loop_valid, lowpri_err}, 0);
                    chk("R1 lo kept", lo_rdata, lo | 32'h1000);
                end
            end
            do_ack();
            chk("R3 busy clears", busy, 0);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset busy", busy, 0);
        chk("R11 reset pulses", {out_valid, loop_valid, lowpri_err}, 0);
        chk("R11 reset lo", lo_rdata, 0);
        chk("R11 reset hi", hi_rdata, 0);
        rst = 1'b0;
        do_ack();
        chk("R3 idle ack ignored", {busy, out_valid}, 0);
        for (int s = 0; s <= 4; s++)
            for (int sh = 0; sh < 4; sh++)
                for (int dm = 0; dm < 2; dm++)
                    for (int d = 0; d <= 16; d++)
                        run_case(s, sh, dm, (d == 16) ? 255 : d, 0,
                                 (s * 37 + sh * 11 + d) & 8'hFF, d & 1, dm);
        run_case(1, 0, 0, 2, 1, 8'h41, 0, 0);
        run_case(1, 0, 1, 3, 1, 8'h42, 1, 1);
        run_case(1, 2, 0, 2, 1, 8'h43, 1, 0);
        run_case(2, 3, 1, 0, 1, 8'h44, 0, 1);
        self_id = 8'd0;
        @(negedge clk);
        wr_hi = 1'b1; hi_wdata = 32'h0200_0000;
        wr_lo = 1'b1; lo_wdata = mk_lo(0, 0, 0, 0, 0, 8'h77);
        @(negedge clk);
        wr_hi = 1'b0; wr_lo = 1'b0;
        chk("R9 same-cycle high", {out_valid, out_mask, out_dest}, {1'b1, 4'b0100, 8'h02});
        do_ack();
        chk("R3 single ack", busy, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule